// File: doc/BRIEF.md
# Two-Channel Reversible H-Bridge PWM Generator

This block produces the gate requests for two H-bridges. Each bridge has its own duty word. A duty word carries direction and drive strength together in offset form. The code at the centre of the range means no drive. Codes below the centre drive the B side (reverse). Codes above it drive the A side (forward). The further a code is from the centre, the longer the active side stays on in each period.

One free-running period counter serves both channels. The resolution select picks 10, 11 or 12 significant bits of the duty word, and the counter period follows that choice. New duty words and a new resolution are taken only at the end of a period, so a period is never cut short or stretched. A reversal between two driven periods inserts a full period with both sides off. A low enable turns the drive off at once.

Top module: `hbridge_pwm`

## Requirements
- R1: Resolution N is chosen by `res_sel`: 0 gives 10 bits, 1 gives 11 bits, and 2 or 3 give 12 bits. The period counter is shared by both channels and its period is 2^(N-1) clock cycles.
- R2: A channel's code is the top N bits of its 12-bit duty word. The 12-N low-order bits have no effect.
- R3: Let mid = 2^(N-1). A code below mid drives `out_b` high for mid-code cycles per period, so code 0 keeps it high for the whole period. `out_a` stays low and `dir_fwd` reads 0.
- R4: A code above mid drives `out_a` high for code-mid cycles per period. `out_b` stays low and `dir_fwd` reads 1.
- R5: A code equal to mid keeps both outputs low for the whole period, and `dir_fwd` reads 1.
- R6: The active output goes high only in the first cycle of a period. It stays high for the magnitude count and is low for the rest of the period.
- R7: Duty words and `res_sel` are sampled only in the last cycle of a period. They take effect from the next period, and `dir_fwd` changes only in the first cycle of a period.
- R8: Suppose a channel's new setting is driven, its current period is driven, and the two directions differ. Then the next period keeps both outputs low, `dir_fwd` already shows the new direction, and the new drive starts one period later. No extra period is inserted when the current period is undriven.
- R9: When `en` is low, both outputs of both channels are low in that same cycle, and the loaded magnitudes are cleared at the clock edge. After `en` returns high, the outputs stay low until a setting is loaded at the next period end.
- R10: While reset is active and until the first period end after it, the outputs are low and `dir_fwd` is 0, whatever the duty words are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Drive enable; low forces both bridges off |
| res_sel | input | 2 | Resolution select (0: 10 bits, 1: 11 bits, 2/3: 12 bits) |
| duty | input | 24 | Duty words; channel c occupies bits [12c+11:12c] |
| out_a | output | 2 | Forward-side gate request per channel |
| out_b | output | 2 | Reverse-side gate request per channel |
| dir_fwd | output | 2 | Loaded direction per channel, 1 = forward |

## Verification
Two actions can fall in the same cycle: loading a new setting at a period end, and either the enable dropping or the blanking decision that follows a reversal. The bench locks onto the start of a period by watching for a rising edge on a partly driven channel. It then lowers `en` exactly in the last cycle of that period. It expects the following period to be fully quiet and the normal pulse count to return one period later. In the same way, it flips the duty word across the centre during a driven period. It then counts active cycles in three back-to-back period windows, expecting the old drive, then silence, then the new drive. When the reversal passes through a centre-code period instead, it expects no silent period.

// File: rtl/hbridge_pwm.sv
module hbridge_pwm #(
  parameter int NCH    = 2,
  parameter int DUTY_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [1:0]              res_sel,
  input  logic [NCH*DUTY_W-1:0]   duty,
  output logic [NCH-1:0]          out_a,
  output logic [NCH-1:0]          out_b,
  output logic [NCH-1:0]          dir_fwd
);
  localparam int CNT_W = DUTY_W - 1;
  localparam int MAG_W = DUTY_W;
  localparam logic [CNT_W-1:0] LAST_LO  = CNT_W'((1 << (CNT_W-2)) - 1);
  localparam logic [CNT_W-1:0] LAST_MID = CNT_W'((1 << (CNT_W-1)) - 1);

  logic [1:0]       res_q;
  logic [CNT_W-1:0] cnt, last;
  logic             wrap;

  always_comb begin
    unique case (res_q)
      2'd0:    last = LAST_LO;
      2'd1:    last = LAST_MID;
      default: last = '1;
    endcase
  end

  assign wrap = (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      res_q <= 2'd0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) res_q <= res_sel;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DUTY_W-1:0] w, code;
    logic [MAG_W-1:0]  mid, mag_n, mag_q;
    logic              fwd_n, dir_q, on;

    assign w = duty[i*DUTY_W +: DUTY_W];

    always_comb begin
      unique case (res_sel)
        2'd0: begin
          code = w >> 2;
          mid  = MAG_W'(1) << (DUTY_W-3);
        end
        2'd1: begin
          code = w >> 1;
          mid  = MAG_W'(1) << (DUTY_W-2);
        end
        default: begin
          code = w;
          mid  = MAG_W'(1) << (DUTY_W-1);
        end
      endcase
      fwd_n = (code >= mid);
      mag_n = fwd_n ? code - mid : mid - code;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mag_q <= '0;
        dir_q <= 1'b0;
      end else if (!en) begin
        mag_q <= '0;
      end else if (wrap) begin
        if (mag_q != '0 && mag_n != '0 && fwd_n != dir_q) mag_q <= '0;
        else                                              mag_q <= mag_n;
        dir_q <= fwd_n;
      end
    end

    assign on         = en && ({1'b0, cnt} < mag_q);
    assign out_a[i]   = on & dir_q;
    assign out_b[i]   = on & ~dir_q;
    assign dir_fwd[i] = dir_q;
  end
endmodule

// File: rtl/hbridge_pwm_chk.sv
module hbridge_pwm_chk #(
  parameter int NCH    = 2,
  parameter int DUTY_W = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  en,
  input logic [DUTY_W-2:0]     cnt,
  input logic [NCH-1:0]        out_a,
  input logic [NCH-1:0]        out_b,
  input logic [NCH-1:0]        dir_fwd
);
  localparam int CNT_W = DUTY_W - 1;
  localparam logic [CNT_W-1:0] L0 = CNT_W'((1 << (CNT_W-2)) - 1);
  localparam logic [CNT_W-1:0] L1 = CNT_W'((1 << (CNT_W-1)) - 1);
  localparam logic [CNT_W-1:0] L2 = '1;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cnt == $past(cnt) + 1'b1) ||
      (cnt == '0 && ($past(cnt) == L0 || $past(cnt) == L1 || $past(cnt) == L2))); // R1

  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (|((out_a & ~$past(out_a)) | (out_b & ~$past(out_b)))) |-> cnt == '0); // R6

  AST_DIR_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_fwd) |-> cnt == '0); // R7

  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (out_a | out_b) == '0); // R9
endmodule

bind hbridge_pwm hbridge_pwm_chk #(.NCH(NCH), .DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt),
  .out_a(out_a), .out_b(out_b), .dir_fwd(dir_fwd)
);

// File: tb/hbridge_pwm_tb.sv
module hbridge_pwm_tb;
  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [1:0]  res_sel = 2'd0;
  logic [23:0] duty = '0;
  logic [1:0]  out_a, out_b, dir_fwd;
  int n_chk = 0, n_fail = 0, prev_p = 512;

  hbridge_pwm u_dut (.clk(clk), .rst_n(rst_n), .en(en), .res_sel(res_sel),
                     .duty(duty), .out_a(out_a), .out_b(out_b), .dir_fwd(dir_fwd));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int per(input int rs);
    return rs == 0 ? 512 : rs == 1 ? 1024 : 2048;
  endfunction

  function automatic void expect_of(input logic [11:0] w, input int rs,
                                    output int mag, output bit fwd);
    int n    = rs == 0 ? 10 : rs == 1 ? 11 : 12;
    int code = int'(w) >> (12 - n);
    int mid  = 1 << (n - 1);
    fwd = code >= mid;
    mag = fwd ? code - mid : mid - code;
  endfunction

  task automatic count_win(input int p, output int a0, output int b0,
                           output int a1, output int b1, output int f0, output int f1);
    a0 = 0; b0 = 0; a1 = 0; b1 = 0; f0 = 0; f1 = 0;
    for (int k = 0; k < p; k++) begin
      a0 += int'(out_a[0]); b0 += int'(out_b[0]);
      a1 += int'(out_a[1]); b1 += int'(out_b[1]);
      f0 += int'(dir_fwd[0]); f1 += int'(dir_fwd[1]);
      @(negedge clk);
    end
  endtask

  task automatic run_steady(input logic [11:0] d0, input logic [11:0] d1, input int rs);
    int p = per(rs);
    int a0, b0, a1, b1, f0, f1, m0, m1;
    bit w0, w1;
    duty = {d1, d0}; res_sel = 2'(rs);
    repeat (prev_p + 2*p) @(negedge clk);
    prev_p = p;
    expect_of(d0, rs, m0, w0);
    expect_of(d1, rs, m1, w1);
    count_win(p, a0, b0, a1, b1, f0, f1);
    // R3 R4 R5 R2 R1: per-period active counts against the decoded magnitude
    chk(a0 == (w0 ? m0 : 0), w0 ? "R4 ch0 out_a" : "R3 ch0 out_a", a0, w0 ? m0 : 0);
    chk(b0 == (w0 ? 0 : m0), w0 ? "R4 ch0 out_b" : "R3 ch0 out_b", b0, w0 ? 0 : m0);
    chk(f0 == (w0 ? p : 0), m0 == 0 ? "R5 ch0 dir" : "R2 ch0 dir", f0, w0 ? p : 0);
    chk(a1 == (w1 ? m1 : 0), w1 ? "R4 ch1 out_a" : "R3 ch1 out_a", a1, w1 ? m1 : 0);
    chk(b1 == (w1 ? 0 : m1), w1 ? "R4 ch1 out_b" : "R3 ch1 out_b", b1, w1 ? 0 : m1);
    chk(f1 == (w1 ? p : 0), m1 == 0 ? "R5 ch1 dir" : "R2 ch1 dir", f1, w1 ? p : 0);
  endtask

  task automatic sync_rise0(input bit side_b);
    logic prev = 1'b1;
    forever begin
      logic cur = side_b ? out_b[0] : out_a[0];
      if (cur && !prev) break;
      prev = cur;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int a0, b0, a1, b1, f0, f1, gap;
    duty = {12'h000, 12'hC00};
    en = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_a == 2'b00 && out_b == 2'b00, "R10 outputs in reset", int'({out_a, out_b}), 0);
    chk(dir_fwd == 2'b00, "R10 dir in reset", int'(dir_fwd), 0);
    rst_n = 1'b1;
    count_win(500, a0, b0, a1, b1, f0, f1);
    chk(a0 + b0 + a1 + b1 == 0, "R10 quiet before first load", a0 + b0 + a1 + b1, 0);
    chk(f0 + f1 == 0, "R10 dir before first load", f0 + f1, 0);

    // 10-bit sweep, low bits set to junk to show they are ignored (R2)
    for (int k = 0; k < 32; k++) begin
      int c0 = k * 33, c1 = 1023 - k * 33;
      run_steady(12'((c0 << 2) | 3), 12'((c1 << 2) | 1), 0);
    end
    run_steady(12'h803, 12'h7FF, 0);     // mid with junk bits; 511 reverse -> mag 1
    run_steady(12'h804, 12'h000, 0);     // 513 forward mag 1; full reverse
    run_steady(12'hFFF, 12'h7FC, 0);     // 511 forward; 511 reverse code -> mag 1

    // 11-bit and 12-bit
    run_steady(12'hFFF, 12'h001, 1);
    run_steady(12'h802, 12'h5A3, 1);
    sync_rise0(1'b0);
    @(negedge clk); gap = 1;
    while (!(out_a[0] && gap > 2)) begin @(negedge clk); gap++; end
    chk(gap == 1024, "R1 11-bit period", gap, 1024);
    run_steady(12'hFFF, 12'h000, 2);
    run_steady(12'h801, 12'h7FF, 2);
    run_steady(12'h3A7, 12'hC5B, 3);

    // Reversal with blanking (R8): ch0 forward 100 -> reverse 60
    run_steady(12'((612 << 2)), 12'((512 << 2)), 0);
    sync_rise0(1'b0);
    duty[11:0] = 12'((452 << 2));
    count_win(512, a0, b0, a1, b1, f0, f1);
    chk(a0 == 100, "R7 old drive kept for current period", a0, 100);
    count_win(512, a0, b0, a1, b1, f0, f1);
    chk(a0 + b0 == 0, "R8 blank period after reversal", a0 + b0, 0);
    chk(f0 == 0, "R8 dir shows new direction in blank", f0, 0);
    count_win(512, a0, b0, a1, b1, f0, f1);
    chk(b0 == 60 && a0 == 0, "R8 new drive after blank", b0, 60);

    // Reversal through a mid period: no extra blank (R8)
    duty[11:0] = 12'((560 << 2));
    repeat (1536) @(negedge clk);
    sync_rise0(1'b0);
    duty[11:0] = 12'((512 << 2));
    count_win(512, a0, b0, a1, b1, f0, f1);
    chk(a0 == 48, "R7 drive before mid", a0, 48);
    duty[11:0] = 12'((482 << 2));
    count_win(512, a0, b0, a1, b1, f0, f1);
    chk(a0 + b0 == 0, "R5 mid period quiet", a0 + b0, 0);
    count_win(512, a0, b0, a1, b1, f0, f1);
    chk(b0 == 30, "R8 no blank after undriven period", b0, 30);

    // Enable dropped in the last cycle of a period (R9)
    run_steady(12'((540 << 2)), 12'h000, 0);
    sync_rise0(1'b0);
    count_win(511, a0, b0, a1, b1, f0, f1);
    chk(a0 == 28 && b1 == 511, "R6 pulse from period start", a0, 28);
    en = 1'b0;
    #1;
    chk(out_b[1] == 1'b0 && out_a[0] == 1'b0, "R9 immediate off", int'(out_b[1]), 0);
    @(negedge clk);
    en = 1'b1;
    count_win(512, a0, b0, a1, b1, f0, f1);
    chk(a0 + b1 == 0, "R9 quiet period after enable returns", a0 + b1, 0);
    count_win(512, a0, b0, a1, b1, f0, f1);
    chk(a0 == 28, "R9 ch0 drive resumes", a0, 28);
    chk(b1 == 512, "R9 ch1 full drive resumes", b1, 512);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule